// File: doc/BRIEF.md
# USB host transmit endpoint control

This block is the control and status logic of one host-side transmit endpoint, the endpoint that issues OUT or SETUP transactions. Software sees an 8-bit control/status register. It loads a packet into the endpoint FIFO and then marks the packet ready. The block tracks how many packets are queued and offers each head packet to the transaction engine. The offer carries the token to use and the current data toggle. The engine reports one handshake outcome per transaction. The outcome is ACK, NAK or STALL, or a timeout when no handshake came back.

Protocol events act directly on the register bits. A STALL empties the FIFO, aborts DMA and halts the endpoint. A packet marked as SETUP forces the data toggle to zero. Three transmissions in a row with no handshake raise an error and halt the endpoint. NAK replies that last longer than a programmable number of frames also halt it. One pulsed interrupt reports completion, STALL, error, NAK timeout and flush. A parameter selects single or double buffering. It changes when hardware clears the packet-ready bit.

The transaction offer is a valid/ready stream. `txn_valid` rises when a packet is queued, no transaction is in flight and the endpoint is not halted. While `txn_ready` is low the offer holds, together with `txn_setup` and `txn_toggle`. A STALL, a flush or a halt may withdraw it. A transfer happens on a cycle where both are high. After that the endpoint waits for exactly one `res_valid` pulse. Results that arrive while nothing is in flight are ignored.

Top module: `usb_host_tx_ep_ctrl`

## Requirements
- R1: After reset the register reads 0x00, no transaction is offered, the data toggle is 0 and every pulse output is low.
- R2: Register bit positions: 7 NAK-halt, 6 toggle-clear, 5 stall-seen, 4 setup-select, 3 flush, 2 error, 1 FIFO-not-empty, 0 packet-ready. Writing 1 to bits 7, 5 or 2 has no effect, and writing 0 to one of them clears it. Bit 1 ignores writes. Writing 0 to bit 0 has no effect. Bit 4 holds the value last written.
- R3: Writing 1 to bit 6 makes the data toggle 0 from the next cycle on. Bit 6 reads 1 for one cycle and then returns to 0 by itself.
- R4: A STALL result sets bit 5, empties the whole FIFO queue and clears packet-ready. One cycle later it pulses `dma_abort`, `fifo_clear_all` and `irq`. While bit 5 is set nothing is offered.
- R5: A packet committed while bit 4 is 1 is offered with `txn_setup`=1. A single write that sets bits 4 and 0 together clears the data toggle.
- R6: Writing 1 to bit 3 discards the most recently queued packet and clears packet-ready. One cycle later it pulses `fifo_drop_last` and `irq`. Bit 3 reads 1 for one cycle and then clears itself.
- R7: The third timeout result in a row, with no handshake in between, sets bit 2 and pulses `irq`. While bit 2 is set nothing is offered.
- R8: Bit 1 reads 1 exactly while at least one packet is queued, and the queue never holds more than BUFS packets.
- R9: With BUFS=1, packet-ready stays 1 until the packet is acknowledged. With BUFS=2, packet-ready clears one cycle after being set if a slot is free. If both slots are full it stays set until a slot frees.
- R10: An ACK result inverts the data toggle. NAK, STALL and timeout results leave it unchanged.
- R11: After a NAK result the endpoint counts `frame_tick` pulses. The tick that arrives when the count already equals a non-zero `nak_limit` sets bit 7, pulses `irq` and halts the endpoint. A `nak_limit` of 0 disables this. Any non-NAK result restarts the count.
- R12: The count of consecutive timeouts returns to 0 on an ACK or NAK result and whenever a new packet is committed.
- R13: A pending offer holds `txn_valid` until it is accepted. Nothing is offered while a transaction is in flight. An ACK result pops the packet and pulses `irq` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read value |
| nak_limit | input | NAK_W | NAK-halt limit in frames, 0 disables |
| frame_tick | input | 1 | One pulse per frame |
| txn_valid | output | 1 | Transaction offer valid |
| txn_ready | input | 1 | Engine accepts the offer |
| txn_setup | output | 1 | Offer uses a SETUP token (else OUT) |
| txn_toggle | output | 1 | Data toggle for the offer |
| res_valid | input | 1 | Result pulse for the transaction in flight |
| res_code | input | 2 | Result: 0 ACK, 1 NAK, 2 STALL, 3 timeout |
| fifo_drop_last | output | 1 | Pulse: discard newest FIFO packet |
| fifo_clear_all | output | 1 | Pulse: empty FIFO and reset its pointers |
| dma_abort | output | 1 | Pulse: stop the pending DMA request |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench builds two instances, one with BUFS=1 and one with BUFS=2, both with NAK_W=8 and MAX_TRIES=3. The single-buffered instance carries the directed and random sequences. The double-buffered one is the only way to reach a full two-slot queue, the held packet-ready bit and a flush that removes the newer of two packets. During the directed runs `nak_limit` is driven to 2, so a NAK halt, and its restart by a timeout result, occur within a few frame ticks. Then it is set to 0 to show that the timer is disabled.

// File: rtl/usb_txep_pkg.sv
package usb_txep_pkg;
  typedef enum logic [1:0] {
    RES_ACK   = 2'd0,
    RES_NAK   = 2'd1,
    RES_STALL = 2'd2,
    RES_TMO   = 2'd3
  } txep_res_e;

  localparam int unsigned B_NAK_HALT = 7;
  localparam int unsigned B_TOG_CLR  = 6;
  localparam int unsigned B_STALLED  = 5;
  localparam int unsigned B_SETUP    = 4;
  localparam int unsigned B_FLUSH    = 3;
  localparam int unsigned B_ERROR    = 2;
  localparam int unsigned B_NEMPTY   = 1;
  localparam int unsigned B_PKT_RDY  = 0;
endpackage

// File: rtl/txep_pkt_queue.sv
module txep_pkt_queue #(
  parameter int unsigned BUFS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit_i,
  input  logic commit_setup_i,
  input  logic pop_i,
  input  logic drop_last_i,
  input  logic clear_i,
  output logic empty_o,
  output logic full_o,
  output logic head_setup_o,
  output logic last_one_o
);
  localparam int unsigned CW = $clog2(BUFS + 1);

  logic [CW-1:0]   count_q, count_n;
  logic [BUFS-1:0] tok_q, tok_n;
  logic            push_ok, pop_ok;

  assign empty_o      = (count_q == '0);
  assign full_o       = (count_q == CW'(BUFS));
  assign last_one_o   = (count_q == CW'(1));
  assign head_setup_o = tok_q[0];
  assign push_ok      = commit_i && !full_o;
  assign pop_ok       = pop_i && !empty_o;

  always_comb begin
    tok_n   = tok_q;
    count_n = count_q;
    if (clear_i) begin
      tok_n   = '0;
      count_n = '0;
    end else if (drop_last_i) begin
      if (!empty_o) count_n = count_q - CW'(1);
    end else begin
      if (pop_ok) begin
        tok_n   = tok_q >> 1;
        count_n = count_q - CW'(1);
      end
      if (push_ok) begin
        for (int i = 0; i < int'(BUFS); i++) begin
          if (i == int'(count_n)) tok_n[i] = commit_setup_i;
        end
        count_n = count_n + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      tok_q   <= '0;
    end else begin
      count_q <= count_n;
      tok_q   <= tok_n;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(BUFS));
  assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (count_q == '0));
  assert_drop_newest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_last_i && !clear_i && count_q != '0) |=> (count_q == $past(count_q) - CW'(1)));
endmodule

// File: rtl/txep_retry_ctr.sv
module txep_retry_ctr #(
  parameter int unsigned MAX_TRIES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic miss_i,
  output logic limit_o
);
  localparam int unsigned TW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
  localparam logic [TW-1:0] LAST = TW'(MAX_TRIES - 1);

  logic [TW-1:0] miss_q;

  assign limit_o = miss_i && !clear_i && (miss_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_q <= '0;
    end else if (clear_i) begin
      miss_q <= '0;
    end else if (miss_i) begin
      miss_q <= (miss_q == LAST) ? '0 : miss_q + TW'(1);
    end
  end

  assert_miss_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q <= LAST);
  assert_miss_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (miss_q == '0));
endmodule

// File: rtl/txep_nak_timer.sv
module txep_nak_timer #(
  parameter int unsigned NAK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nak_i,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [NAK_W-1:0] limit_i,
  output logic             expire_o
);
  logic             active_q;
  logic [NAK_W-1:0] frames_q;
  logic             counting;

  assign counting = active_q && tick_i && (limit_i != '0) && !restart_i;
  assign expire_o = counting && (frames_q == limit_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      frames_q <= '0;
    end else if (restart_i) begin
      active_q <= 1'b0;
      frames_q <= '0;
    end else begin
      if (nak_i) active_q <= 1'b1;
      if (counting) begin
        if (frames_q == limit_i) begin
          active_q <= 1'b0;
          frames_q <= '0;
        end else begin
          frames_q <= frames_q + NAK_W'(1);
        end
      end
    end
  end

  assert_frame_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && frames_q != limit_i) |=> (frames_q == $past(frames_q) + NAK_W'(1)));
  assert_restart_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (!active_q && frames_q == '0));
endmodule

// File: rtl/usb_host_tx_ep_ctrl.sv
module usb_host_tx_ep_ctrl
  import usb_txep_pkg::*;
#(
  parameter int unsigned BUFS      = 1,
  parameter int unsigned NAK_W     = 8,
  parameter int unsigned MAX_TRIES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr_en,
  input  logic [7:0]       csr_wdata,
  output logic [7:0]       csr_rdata,
  input  logic [NAK_W-1:0] nak_limit,
  input  logic             frame_tick,
  output logic             txn_valid,
  input  logic             txn_ready,
  output logic             txn_setup,
  output logic             txn_toggle,
  input  logic             res_valid,
  input  logic [1:0]       res_code,
  output logic             fifo_drop_last,
  output logic             fifo_clear_all,
  output logic             dma_abort,
  output logic             irq
);
  logic nak_halt_q, tog_clr_q, stalled_q, setup_q, flush_q, err_q, pkt_rdy_q;
  logic toggle_q, in_flight_q;
  logic irq_q, abort_q, clear_all_q, drop_q;

  txep_res_e code;
  logic res_take, is_ack, is_nak, is_stall, is_tmo;
  logic halted, fire, flush_wr, commit, setup_wr, tog_wr;
  logic q_empty, q_full, q_head_setup, q_last_one;
  logic err_ev, nak_expire;
  logic clr_on_commit, clr_on_ack;
  logic unused_wbit;

  assign unused_wbit = csr_wdata[B_NEMPTY];

  generate
    if (BUFS == 1) begin : g_single_buf
      assign clr_on_commit = 1'b0;
      assign clr_on_ack    = 1'b1;
    end else begin : g_multi_buf
      assign clr_on_commit = 1'b1;
      assign clr_on_ack    = 1'b0;
    end
  endgenerate

  assign code     = txep_res_e'(res_code);
  assign res_take = res_valid && in_flight_q;
  assign is_ack   = res_take && (code == RES_ACK);
  assign is_nak   = res_take && (code == RES_NAK);
  assign is_stall = res_take && (code == RES_STALL);
  assign is_tmo   = res_take && (code == RES_TMO);

  assign halted    = nak_halt_q || stalled_q || err_q;
  assign txn_valid = !q_empty && !in_flight_q && !halted;
  assign fire      = txn_valid && txn_ready;
  assign flush_wr  = csr_wr_en && csr_wdata[B_FLUSH];
  assign commit    = pkt_rdy_q && !q_full && !flush_wr && !is_stall;
  assign setup_wr  = csr_wr_en && csr_wdata[B_SETUP] && csr_wdata[B_PKT_RDY];
  assign tog_wr    = csr_wr_en && csr_wdata[B_TOG_CLR];

  txep_pkt_queue #(.BUFS(BUFS)) u_queue (
    .clk            (clk),
    .rst_n          (rst_n),
    .commit_i       (commit),
    .commit_setup_i (setup_q),
    .pop_i          (is_ack),
    .drop_last_i    (flush_wr),
    .clear_i        (is_stall),
    .empty_o        (q_empty),
    .full_o         (q_full),
    .head_setup_o   (q_head_setup),
    .last_one_o     (q_last_one)
  );

  txep_retry_ctr #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (is_ack || is_nak || commit),
    .miss_i  (is_tmo),
    .limit_o (err_ev)
  );

  txep_nak_timer #(.NAK_W(NAK_W)) u_nak_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .nak_i     (is_nak),
    .restart_i (res_take && !is_nak),
    .tick_i    (frame_tick),
    .limit_i   (nak_limit),
    .expire_o  (nak_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nak_halt_q  <= 1'b0;
      tog_clr_q   <= 1'b0;
      stalled_q   <= 1'b0;
      setup_q     <= 1'b0;
      flush_q     <= 1'b0;
      err_q       <= 1'b0;
      pkt_rdy_q   <= 1'b0;
      toggle_q    <= 1'b0;
      in_flight_q <= 1'b0;
      irq_q       <= 1'b0;
      abort_q     <= 1'b0;
      clear_all_q <= 1'b0;
      drop_q      <= 1'b0;
    end else begin
      if (nak_expire) nak_halt_q <= 1'b1;
      else if (csr_wr_en && !csr_wdata[B_NAK_HALT]) nak_halt_q <= 1'b0;

      if (is_stall) stalled_q <= 1'b1;
      else if (csr_wr_en && !csr_wdata[B_STALLED]) stalled_q <= 1'b0;

      if (err_ev) err_q <= 1'b1;
      else if (csr_wr_en && !csr_wdata[B_ERROR]) err_q <= 1'b0;

      tog_clr_q <= tog_wr;
      flush_q   <= flush_wr;
      if (csr_wr_en) setup_q <= csr_wdata[B_SETUP];

      if (is_stall || flush_wr) pkt_rdy_q <= 1'b0;
      else if (csr_wr_en && csr_wdata[B_PKT_RDY]) pkt_rdy_q <= 1'b1;
      else if (commit && clr_on_commit) pkt_rdy_q <= 1'b0;
      else if (is_ack && clr_on_ack) pkt_rdy_q <= 1'b0;

      if (tog_wr || setup_wr) toggle_q <= 1'b0;
      else if (is_ack) toggle_q <= !toggle_q;

      if (fire) in_flight_q <= 1'b1;
      else if (res_take || is_stall) in_flight_q <= 1'b0;
      else if (flush_wr && q_last_one) in_flight_q <= 1'b0;

      irq_q       <= is_ack || is_stall || err_ev || nak_expire || flush_wr;
      abort_q     <= is_stall;
      clear_all_q <= is_stall;
      drop_q      <= flush_wr;
    end
  end

  assign csr_rdata = {nak_halt_q, tog_clr_q, stalled_q, setup_q,
                      flush_q, err_q, !q_empty, pkt_rdy_q};
  assign txn_setup      = q_head_setup;
  assign txn_toggle     = toggle_q;
  assign irq            = irq_q;
  assign dma_abort      = abort_q;
  assign fifo_clear_all = clear_all_q;
  assign fifo_drop_last = drop_q;

  assert_stall_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stalled_q) |-> (q_empty && !pkt_rdy_q && irq && dma_abort));
  assert_ack_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ack && !csr_wr_en) |=> (toggle_q != $past(toggle_q)));
  assert_keep_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_take && !is_ack && !csr_wr_en) |=> $stable(toggle_q));
  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(res_valid && res_code == 2'd3));
  assert_flush_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_q && !csr_wr_en) |=> !flush_q);
  assert_hold_offer_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready && !csr_wr_en && !res_valid && !frame_tick) |=> txn_valid);
  assert_togclr_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_clr_q && !csr_wr_en) |=> !tog_clr_q);
endmodule

// File: tb/test_usb_host_tx_ep_ctrl.sv
module test_usb_host_tx_ep_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, csr_wr_en, frame_tick, txn_ready, res_valid;
  logic [7:0] csr_wdata, nak_limit;
  logic [1:0] res_code;
  logic [7:0] rdata_s, rdata_d;
  logic valid_s, setup_s, tog_s, drop_s, clrall_s, abort_s, irq_s;
  logic valid_d, setup_d, tog_d, drop_d, clrall_d, abort_d, irq_d;

  int checks = 0;
  int fails  = 0;
  logic exp_tog;

  localparam logic [1:0] C_ACK = 2'd0, C_NAK = 2'd1, C_STALL = 2'd2, C_TMO = 2'd3;

  always #(CLK_PERIOD/2) clk = !clk;

  usb_host_tx_ep_ctrl #(.BUFS(1), .NAK_W(8), .MAX_TRIES(3)) i_usb_host_tx_ep_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_wdata(csr_wdata),
    .csr_rdata(rdata_s), .nak_limit(nak_limit), .frame_tick(frame_tick),
    .txn_valid(valid_s), .txn_ready(txn_ready), .txn_setup(setup_s),
    .txn_toggle(tog_s), .res_valid(res_valid), .res_code(res_code),
    .fifo_drop_last(drop_s), .fifo_clear_all(clrall_s), .dma_abort(abort_s),
    .irq(irq_s));

  usb_host_tx_ep_ctrl #(.BUFS(2), .NAK_W(8), .MAX_TRIES(3)) i_usb_host_tx_ep_ctrl_db (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_wdata(csr_wdata),
    .csr_rdata(rdata_d), .nak_limit(nak_limit), .frame_tick(frame_tick),
    .txn_valid(valid_d), .txn_ready(txn_ready), .txn_setup(setup_d),
    .txn_toggle(tog_d), .res_valid(res_valid), .res_code(res_code),
    .fifo_drop_last(drop_d), .fifo_clear_all(clrall_d), .dma_abort(abort_d),
    .irq(irq_d));

  function automatic logic next_tog(input logic t, input logic [1:0] c);
    return (c == C_ACK) ? !t : t;
  endfunction

  function automatic logic tog_after_write(input logic t, input logic [7:0] w);
    return (w[6] || (w[4] && w[0])) ? 1'b0 : t;
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; csr_wr_en = 1'b0; csr_wdata = '0; frame_tick = 1'b0;
    txn_ready = 1'b0; res_valid = 1'b0; res_code = '0; nak_limit = 8'd2;
    exp_tog = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic wr(input logic [7:0] d);
    csr_wr_en = 1'b1; csr_wdata = d;
    exp_tog = tog_after_write(exp_tog, d);
    cyc();
    csr_wr_en = 1'b0; csr_wdata = '0;
  endtask

  task automatic hs(input logic [1:0] c);
    res_valid = 1'b1; res_code = c;
    exp_tog = next_tog(exp_tog, c);
    cyc();
    res_valid = 1'b0;
  endtask

  task automatic tick();
    frame_tick = 1'b1;
    cyc();
    frame_tick = 1'b0;
  endtask

  task automatic send(input string req);
    int guard = 0;
    while (!valid_s && guard < 20) begin cyc(); guard++; end
    chk(req, valid_s, 1'b1);
    txn_ready = 1'b1;
    cyc();
    txn_ready = 1'b0;
  endtask

  task automatic send_db(input string req);
    int guard = 0;
    while (!valid_d && guard < 20) begin cyc(); guard++; end
    chk(req, valid_d, 1'b1);
    txn_ready = 1'b1;
    cyc();
    txn_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();

    // R1 reset state
    chk("R1 rdata", rdata_s, 8'h00);
    chk("R1 valid", valid_s, 1'b0);
    chk("R1 toggle", tog_s, 1'b0);
    chk("R1 pulses", {irq_s, abort_s, clrall_s, drop_s}, 4'h0);

    // R2 writing 1 to status bits and to bit 1 changes nothing
    wr(8'hA6);
    chk("R2 write ones to status", rdata_s, 8'h00);

    // R5 R13 setup packet, hold offer, ACK
    wr(8'h11);
    cyc();
    chk("R5 commit read", rdata_s, 8'h13);
    chk("R5 setup token", setup_s, 1'b1);
    chk("R5 toggle zero", tog_s, 1'b0);
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R13 offer held", valid_s, 1'b1);
    end
    send("R13 offer");
    chk("R13 no offer in flight", valid_s, 1'b0);
    hs(C_ACK);
    chk("R13 ack irq", irq_s, 1'b1);
    chk("R10 ack flips toggle", tog_s, exp_tog);
    chk("R9 single clears on ack", rdata_s, 8'h10);

    // R10 NAK and timeout keep toggle
    wr(8'h01);
    cyc();
    chk("R5 out token", setup_s, 1'b0);
    send("R10 offer");
    hs(C_NAK);
    chk("R10 nak keeps toggle", tog_s, exp_tog);
    send("R10 offer");
    hs(C_TMO);
    chk("R10 timeout keeps toggle", tog_s, exp_tog);
    send("R10 offer");
    hs(C_ACK);
    chk("R10 ack flips toggle", tog_s, exp_tog);

    // R12 retry count resets on ACK; R7 third timeout errors
    wr(8'h01); cyc();
    send("R12 offer"); hs(C_TMO);
    send("R12 offer"); hs(C_TMO);
    send("R12 offer"); hs(C_ACK);
    wr(8'h01); cyc();
    send("R12 offer"); hs(C_TMO);
    send("R12 offer"); hs(C_TMO);
    chk("R12 no error after two", rdata_s, 8'h03);
    send("R7 offer"); hs(C_TMO);
    chk("R7 error set", rdata_s, 8'h07);
    chk("R7 error irq", irq_s, 1'b1);
    cyc();
    chk("R7 halted", valid_s, 1'b0);
    wr(8'h00);
    chk("R2 write zero clears error", rdata_s, 8'h03);
    send("R7 offer"); hs(C_TMO);
    send("R7 offer"); hs(C_TMO);
    chk("R12 count restarted", rdata_s, 8'h03);
    send("R7 offer"); hs(C_ACK);
    chk("R9 packet done", rdata_s, 8'h00);

    // R3 toggle clear
    wr(8'h01); cyc();
    send("R3 offer"); hs(C_ACK);
    chk("R3 toggle before", tog_s, exp_tog);
    wr(8'h40);
    chk("R3 bit reads one", rdata_s, 8'h40);
    chk("R3 toggle cleared", tog_s, 1'b0);
    cyc();
    chk("R3 bit self clears", rdata_s, 8'h00);

    // R6 flush
    wr(8'h01); cyc();
    chk("R8 not empty", rdata_s, 8'h03);
    wr(8'h08);
    chk("R6 flush read", rdata_s, 8'h08);
    chk("R6 drop pulse", drop_s, 1'b1);
    chk("R6 flush irq", irq_s, 1'b1);
    cyc();
    chk("R6 flush self clears", rdata_s, 8'h00);
    chk("R6 drop pulse ends", drop_s, 1'b0);

    // R4 stall
    wr(8'h01); cyc();
    send("R4 offer");
    hs(C_STALL);
    chk("R4 stall read", rdata_s, 8'h20);
    chk("R4 pulses", {irq_s, abort_s, clrall_s}, 3'b111);
    chk("R10 stall keeps toggle", tog_s, exp_tog);
    wr(8'h21);
    cyc();
    chk("R2 write one keeps stall", rdata_s, 8'h23);
    chk("R4 halted", valid_s, 1'b0);
    wr(8'h01);
    chk("R4 cleared", rdata_s, 8'h03);
    send("R4 offer"); hs(C_ACK);

    // R11 NAK halt timer, limit 2
    nak_limit = 8'd2;
    wr(8'h01); cyc();
    send("R11 offer"); hs(C_NAK);
    tick(); tick();
    chk("R11 not yet", rdata_s, 8'h03);
    tick();
    chk("R11 nak halt", rdata_s, 8'h83);
    chk("R11 irq", irq_s, 1'b1);
    chk("R11 halted", valid_s, 1'b0);
    wr(8'h01);
    chk("R11 cleared", rdata_s, 8'h03);
    send("R11 offer"); hs(C_NAK);
    tick();
    send("R11 offer"); hs(C_TMO);
    send("R11 offer"); hs(C_NAK);
    tick(); tick();
    chk("R11 restart by timeout", rdata_s, 8'h03);
    nak_limit = 8'd0;
    tick(); tick(); tick();
    chk("R11 limit zero disables", rdata_s, 8'h03);
    send("R11 offer"); hs(C_ACK);

    // R9 R8 R6 double buffered instance
    do_reset();
    wr(8'h01);
    chk("R9 db set", rdata_d, 8'h01);
    cyc();
    chk("R9 db cleared after commit", rdata_d, 8'h02);
    wr(8'h11); cyc();
    chk("R9 db second commit", rdata_d, 8'h12);
    wr(8'h01); cyc(); cyc();
    chk("R9 db held when full", rdata_d, 8'h03);
    chk("R5 db head out", setup_d, 1'b0);
    send_db("R13 db offer");
    hs(C_ACK);
    chk("R9 db still held at ack", rdata_d, 8'h03);
    chk("R5 db next head setup", setup_d, 1'b1);
    cyc();
    chk("R9 db commits after ack", rdata_d, 8'h02);
    wr(8'h08);
    chk("R6 db flush newest", rdata_d, 8'h0A);
    chk("R5 db head kept", setup_d, 1'b1);

    // random phase on single instance: R10 R5 R13
    do_reset();
    nak_limit = 8'd0;
    for (int p = 0; p < 30; p++) begin
      logic su;
      int tmo_run;
      su = 1'($urandom % 2);
      wr(su ? 8'h11 : 8'h01);
      cyc();
      tmo_run = 0;
      for (int k = 0; k < 20; k++) begin
        logic [1:0] c;
        int r;
        r = int'($urandom % 3);
        c = (r == 0 || k == 19) ? C_ACK : (r == 1) ? C_NAK :
            (tmo_run < 2) ? C_TMO : C_ACK;
        chk("R10 random toggle", tog_s, exp_tog);
        chk("R5 random token", setup_s, su);
        send("R13 random offer");
        hs(c);
        if (c == C_TMO) tmo_run++;
        else tmo_run = 0;
        if (c == C_ACK) break;
      end
      chk("R9 random done", rdata_s, su ? 8'h10 : 8'h00);
    end

    report();
    $finish;
  end
endmodule